// File: doc/BRIEF.md
# Programmable Almost-Empty / Almost-Full Flag Unit

This block produces early-warning status for a pair of FIFO directions. It holds four offset values: an almost-full threshold and an almost-empty threshold for the first direction (Y1, X1), and the same pair for the second direction (Y2, X2). Every clock it compares each direction's stored-word count and free-location count against these thresholds, and it registers the outcome onto four active-low flags. The word counts arrive already synchronized to the block clock. The FIFO storage and its pointers live outside this block.

The thresholds can be set in one of three ways, chosen by a 3-bit select that is sampled while master reset is low and held from the moment reset is released. The first way applies a fixed preset to all four thresholds. The second loads them one after another from a 36-bit parallel bus. The third shifts them in through a single serial chain that runs through all four registers. A small load sequencer handles the chosen method. Its states are ST_SHIFT (serial chain open), ST_PY1, ST_PX1, ST_PY2 and ST_PX2 (waiting for the parallel write to that register), and ST_HOLD (thresholds frozen).

The sequencer has the following transitions:
- Master reset enters ST_SHIFT for serial mode, ST_PY1 for parallel mode, and ST_HOLD for a preset.
- ST_SHIFT moves to ST_HOLD when the last chain bit is accepted.
- Each parallel state moves to the next one, in the order ST_PY1, ST_PX1, ST_PY2, ST_PX2, ST_HOLD, on each load strobe.
- ST_HOLD is left only through master reset.

A partial reset forces the flags inactive but leaves the thresholds and the sequencer untouched.

Top module: `almost_flag_unit`

## Requirements
- R1: `ae1_n` goes low one clock after `fill1` <= X1, and high otherwise. `ae2_n` behaves the same way with `fill2` and X2. The comparison includes equality.
- R2: `af1_n` goes low one clock after `free1` <= Y1, and high otherwise. `af2_n` behaves the same way with `free2` and Y2.
- R3: The value of `cfg_sel` at master reset release picks the mode. 0 selects serial and 1 or 7 selects parallel; both of these start with all four thresholds at 0. Codes 2, 3, 4, 5 and 6 load 8, 16, 64, 256 and 1024 respectively into all four thresholds.
- R4: In serial mode, each clock edge with `ser_en_n` low shifts `ser_bit` into the chain. The chain is 4*OFS_W bits long and is ordered Y1, X1, Y2, X2, each register MSB first. The first bit therefore lands in the Y1 MSB and the last bit in the X2 LSB.
- R5: In serial mode, edges with `ser_en_n` high shift nothing. Once 4*OFS_W bits have been accepted, further serial bits are ignored.
- R6: In parallel mode, successive `par_load` strobes write `par_data[OFS_W-1:0]` into Y1, X1, Y2 and X2, in that order. The upper data bits are ignored, and strobes after the fourth have no effect.
- R7: In a preset mode, neither parallel strobes nor serial bits change any threshold.
- R8: All four flags are high while `mrst_n` is low and while `prst_n` is low.
- R9: A partial reset leaves the thresholds and the load mode unchanged, so after it is released the flags follow the same thresholds as before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| mrst_n | input | 1 | Master reset, active low, synchronous |
| prst_n | input | 1 | Partial reset, active low |
| cfg_sel | input | 3 | Load-mode select, sampled during master reset |
| ser_en_n | input | 1 | Serial shift enable, active low |
| ser_bit | input | 1 | Serial threshold data |
| par_load | input | 1 | Parallel threshold write strobe |
| par_data | input | PAR_W | Parallel threshold data |
| fill1 | input | LVL_W | Stored words, direction 1 |
| free1 | input | LVL_W | Free locations, direction 1 |
| fill2 | input | LVL_W | Stored words, direction 2 |
| free2 | input | LVL_W | Free locations, direction 2 |
| ae1_n | output | 1 | Almost-empty, direction 1, active low |
| af1_n | output | 1 | Almost-full, direction 1, active low |
| ae2_n | output | 1 | Almost-empty, direction 2, active low |
| af2_n | output | 1 | Almost-full, direction 2, active low |

## Verification
A flag reflects a new level one clock after that level is presented. The bench therefore drives each level on a falling edge and samples the flags at the next falling edge, which lies after exactly one rising edge. A threshold write or shift takes effect at its own rising edge, and the flags follow one clock later. The bench completes every load sequence and idles at least one clock before it starts a level sweep. Reset checks are sampled on falling edges while the reset input is still held low.

// File: rtl/aflag_pkg.sv
package aflag_pkg;

    typedef enum logic [2:0] {
        ST_HOLD,
        ST_SHIFT,
        ST_PY1,
        ST_PX1,
        ST_PY2,
        ST_PX2
    } load_state_t;

    // Sequencer entry state for a given mode select.
    function automatic load_state_t entry_state(input logic [2:0] sel);
        case (sel)
            3'd0:       return ST_SHIFT;
            3'd1, 3'd7: return ST_PY1;
            default:    return ST_HOLD;
        endcase
    endfunction

    // Threshold applied at master reset; zero for serial and parallel modes.
    function automatic int unsigned preset_value(input logic [2:0] sel);
        case (sel)
            3'd2:    return 8;
            3'd3:    return 16;
            3'd4:    return 64;
            3'd5:    return 256;
            3'd6:    return 1024;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/aflag_loader.sv
module aflag_loader
    import aflag_pkg::*;
#(
    parameter int OFS_W = 16,
    parameter int PAR_W = 36
) (
    input  logic             clk,
    input  logic             mrst_n,
    input  logic [2:0]       cfg_sel,
    input  logic             ser_en_n,
    input  logic             ser_bit,
    input  logic             par_load,
    input  logic [PAR_W-1:0] par_data,
    output logic [OFS_W-1:0] y1_ofs,
    output logic [OFS_W-1:0] x1_ofs,
    output logic [OFS_W-1:0] y2_ofs,
    output logic [OFS_W-1:0] x2_ofs
);
    localparam int CHAIN_W = 4 * OFS_W;
    localparam int CNT_W   = $clog2(CHAIN_W + 1);

    load_state_t         state_q, state_d;
    logic [CHAIN_W-1:0]  chain_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [1:0]          par_slot;
    logic                par_active;
    logic [OFS_W-1:0]    preset_w;
    logic                unused_par_hi;

    assign preset_w      = OFS_W'(preset_value(cfg_sel));
    assign unused_par_hi = ^par_data;

    // State register
    always_ff @(posedge clk) begin
        if (!mrst_n) state_q <= entry_state(cfg_sel);
        else         state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD:  state_d = ST_HOLD;
            ST_SHIFT: if (!ser_en_n && cnt_q == CNT_W'(CHAIN_W - 1)) state_d = ST_HOLD;
            ST_PY1:   if (par_load) state_d = ST_PX1;
            ST_PX1:   if (par_load) state_d = ST_PY2;
            ST_PY2:   if (par_load) state_d = ST_PX2;
            ST_PX2:   if (par_load) state_d = ST_HOLD;
            default:  state_d = ST_HOLD;
        endcase
    end

    // Parallel target slot: Y1 is the top slice of the chain, X2 the bottom.
    always_comb begin
        par_slot   = 2'd0;
        par_active = 1'b1;
        unique case (state_q)
            ST_PY1:  par_slot = 2'd3;
            ST_PX1:  par_slot = 2'd2;
            ST_PY2:  par_slot = 2'd1;
            ST_PX2:  par_slot = 2'd0;
            default: par_active = 1'b0;
        endcase
    end

    // Output datapath: threshold chain and serial bit counter
    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            chain_q <= {4{preset_w}};
            cnt_q   <= '0;
        end else if (state_q == ST_SHIFT && !ser_en_n) begin
            chain_q <= {chain_q[CHAIN_W-2:0], ser_bit};
            cnt_q   <= cnt_q + CNT_W'(1);
        end else if (par_active && par_load) begin
            chain_q[int'(par_slot) * OFS_W +: OFS_W] <= par_data[OFS_W-1:0];
        end
    end

    assign y1_ofs = chain_q[3*OFS_W +: OFS_W];
    assign x1_ofs = chain_q[2*OFS_W +: OFS_W];
    assign y2_ofs = chain_q[1*OFS_W +: OFS_W];
    assign x2_ofs = chain_q[0*OFS_W +: OFS_W];

    // R5: the frozen state is never left and the thresholds stay put there
    a_r5_hold_sticks: assert property (@(posedge clk) disable iff (!mrst_n)
        state_q == ST_HOLD |=> state_q == ST_HOLD);
    a_r7_hold_stable: assert property (@(posedge clk) disable iff (!mrst_n)
        state_q == ST_HOLD |=> $stable(chain_q));
    // R4: an accepted serial bit appears at the chain tail
    a_r4_bit_enters: assert property (@(posedge clk) disable iff (!mrst_n)
        (state_q == ST_SHIFT && !ser_en_n) |=> chain_q[0] == $past(ser_bit));
    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!mrst_n)
        cnt_q <= CNT_W'(CHAIN_W));
    // R6: parallel strobes step through the registers in order
    a_r6_par_step: assert property (@(posedge clk) disable iff (!mrst_n)
        (state_q == ST_PY1 && par_load) |=> state_q == ST_PX1);

endmodule

// File: rtl/aflag_cmp.sv
module aflag_cmp #(
    parameter int OFS_W = 16,
    parameter int LVL_W = 17
) (
    input  logic             clk,
    input  logic             mrst_n,
    input  logic             prst_n,
    input  logic [LVL_W-1:0] used_lvl,
    input  logic [LVL_W-1:0] free_lvl,
    input  logic [OFS_W-1:0] x_ofs,
    input  logic [OFS_W-1:0] y_ofs,
    output logic             ae_n,
    output logic             af_n
);
    logic [LVL_W-1:0] x_ext, y_ext;

    assign x_ext = LVL_W'(x_ofs);
    assign y_ext = LVL_W'(y_ofs);

    always_ff @(posedge clk) begin
        if (!mrst_n || !prst_n) begin
            ae_n <= 1'b1;
            af_n <= 1'b1;
        end else begin
            ae_n <= !(used_lvl <= x_ext);
            af_n <= !(free_lvl <= y_ext);
        end
    end

    // R8: partial reset forces both flags inactive
    a_r8_prst_high: assert property (@(posedge clk) disable iff (!mrst_n)
        !prst_n |=> (ae_n && af_n));
    // R1: a level at or below X drives almost-empty low one clock later
    a_r1_ae_low: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
        (used_lvl <= x_ext) |=> !ae_n);
    // R2: a free count above Y keeps almost-full high one clock later
    a_r2_af_high: assert property (@(posedge clk) disable iff (!mrst_n || !prst_n)
        (free_lvl > y_ext) |=> af_n);

endmodule

// File: rtl/almost_flag_unit.sv
module almost_flag_unit #(
    parameter int OFS_W = 16,
    parameter int LVL_W = OFS_W + 1,
    parameter int PAR_W = 36
) (
    input  logic             clk,
    input  logic             mrst_n,
    input  logic             prst_n,
    input  logic [2:0]       cfg_sel,
    input  logic             ser_en_n,
    input  logic             ser_bit,
    input  logic             par_load,
    input  logic [PAR_W-1:0] par_data,
    input  logic [LVL_W-1:0] fill1,
    input  logic [LVL_W-1:0] free1,
    input  logic [LVL_W-1:0] fill2,
    input  logic [LVL_W-1:0] free2,
    output logic             ae1_n,
    output logic             af1_n,
    output logic             ae2_n,
    output logic             af2_n
);
    localparam int NDIR = 2;

    logic [OFS_W-1:0] y1_ofs, x1_ofs, y2_ofs, x2_ofs;
    logic [OFS_W-1:0] x_arr [NDIR];
    logic [OFS_W-1:0] y_arr [NDIR];
    logic [LVL_W-1:0] used_arr [NDIR];
    logic [LVL_W-1:0] free_arr [NDIR];
    logic [NDIR-1:0]  ae_arr, af_arr;

    aflag_loader #(.OFS_W(OFS_W), .PAR_W(PAR_W)) u_load (
        .clk      (clk),
        .mrst_n   (mrst_n),
        .cfg_sel  (cfg_sel),
        .ser_en_n (ser_en_n),
        .ser_bit  (ser_bit),
        .par_load (par_load),
        .par_data (par_data),
        .y1_ofs   (y1_ofs),
        .x1_ofs   (x1_ofs),
        .y2_ofs   (y2_ofs),
        .x2_ofs   (x2_ofs)
    );

    assign x_arr[0]    = x1_ofs;
    assign y_arr[0]    = y1_ofs;
    assign x_arr[1]    = x2_ofs;
    assign y_arr[1]    = y2_ofs;
    assign used_arr[0] = fill1;
    assign free_arr[0] = free1;
    assign used_arr[1] = fill2;
    assign free_arr[1] = free2;

    for (genvar g = 0; g < NDIR; g++) begin : g_dir
        aflag_cmp #(.OFS_W(OFS_W), .LVL_W(LVL_W)) u_cmp (
            .clk      (clk),
            .mrst_n   (mrst_n),
            .prst_n   (prst_n),
            .used_lvl (used_arr[g]),
            .free_lvl (free_arr[g]),
            .x_ofs    (x_arr[g]),
            .y_ofs    (y_arr[g]),
            .ae_n     (ae_arr[g]),
            .af_n     (af_arr[g])
        );
    end

    assign ae1_n = ae_arr[0];
    assign af1_n = af_arr[0];
    assign ae2_n = ae_arr[1];
    assign af2_n = af_arr[1];

endmodule

// File: tb/sim_almost_flag_unit.sv
module sim_almost_flag_unit;
    localparam int W  = 16;
    localparam int LW = W + 1;
    localparam int PW = 36;

    logic          clk = 1'b0;
    logic          mrst_n = 1'b0, prst_n = 1'b1;
    logic [2:0]    cfg_sel = 3'd2;
    logic          ser_en_n = 1'b1, ser_bit = 1'b0, par_load = 1'b0;
    logic [PW-1:0] par_data = '0;
    logic [LW-1:0] fill1 = '0, free1 = '0, fill2 = '0, free2 = '0;
    logic          ae1_n, af1_n, ae2_n, af2_n;
    int            checks = 0, errors = 0;

    always #4 clk = ~clk;

    almost_flag_unit #(.OFS_W(W), .PAR_W(PW)) u0 (
        .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .cfg_sel(cfg_sel),
        .ser_en_n(ser_en_n), .ser_bit(ser_bit), .par_load(par_load),
        .par_data(par_data), .fill1(fill1), .free1(free1), .fill2(fill2),
        .free2(free2), .ae1_n(ae1_n), .af1_n(af1_n), .ae2_n(ae2_n), .af2_n(af2_n)
    );

    task automatic chk(input logic got, input logic exp, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", what, got, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic set_levels(input int a, input int b, input int c, input int d);
        fill1 = LW'(a); free1 = LW'(b); fill2 = LW'(c); free2 = LW'(d);
    endtask

    // Drive levels on a falling edge, sample after one rising edge.
    task automatic probe(input int v, input int x1, input int y1,
                         input int x2, input int y2, input string tag);
        set_levels(v, v, v, v);
        @(negedge clk);
        chk(ae1_n, !(v <= x1), {tag, " ae1"});
        chk(af1_n, !(v <= y1), {tag, " af1"});
        chk(ae2_n, !(v <= x2), {tag, " ae2"});
        chk(af2_n, !(v <= y2), {tag, " af2"});
    endtask

    task automatic sweep(input int x1, input int y1, input int x2, input int y2,
                         input int lim, input string tag);
        for (int v = 0; v <= lim; v++) probe(v, x1, y1, x2, y2, tag);
    endtask

    // R8: flags held high through master reset even with empty levels
    task automatic reset_with(input logic [2:0] sel);
        @(negedge clk);
        mrst_n = 1'b0; cfg_sel = sel; par_load = 1'b0; ser_en_n = 1'b1;
        set_levels(0, 0, 0, 0);
        repeat (3) @(negedge clk);
        chk(ae1_n & af1_n & ae2_n & af2_n, 1'b1, "R8 flags high in master reset");
        mrst_n = 1'b1;
    endtask

    task automatic par_write(input logic [PW-1:0] d);
        par_load = 1'b1; par_data = d;
        @(negedge clk);
        par_load = 1'b0;
    endtask

    // Shift MSB first, with an idle (enable high, toggled data) every 8 bits.
    task automatic shift_in(input logic [63:0] val, input int nbits);
        for (int i = nbits - 1; i >= 0; i--) begin
            ser_en_n = 1'b0; ser_bit = val[i];
            @(negedge clk);
            if (i % 8 == 0) begin
                ser_en_n = 1'b1; ser_bit = ~val[i];
                @(negedge clk);
            end
        end
        ser_en_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        // R3: presets applied to all four thresholds
        for (int s = 2; s <= 6; s++) begin
            int pv;
            pv = (s == 2) ? 8 : (s == 3) ? 16 : (s == 4) ? 64 : (s == 5) ? 256 : 1024;
            reset_with(3'(s));
            sweep(pv, pv, pv, pv, pv + 2, "R1 R2 R3 preset");
        end

        // R7: preset mode ignores parallel and serial writes
        reset_with(3'd3);
        @(negedge clk);
        for (int k = 0; k < 5; k++) par_write(36'h0);
        shift_in(64'h0, 64);
        @(negedge clk);
        sweep(16, 16, 16, 16, 18, "R7 preset unchanged");

        // R3/R6: parallel mode (code 7), zero before any write
        reset_with(3'd7);
        probe(0, 0, 0, 0, 0, "R3 parallel start zero");
        probe(1, 0, 0, 0, 0, "R3 parallel start zero");
        par_write(36'hFFFF_F0005);
        par_write(36'h1_2345_0009);
        par_write(36'h0_0000_012C);
        par_write(36'hA_BCDE_004D);
        par_write(36'h0);
        @(negedge clk);
        sweep(9, 5, 77, 300, 305, "R6 parallel order");

        // R4/R5: serial chain Y1=3 X1=12 Y2=40 X2=100, gaps and surplus bits
        reset_with(3'd0);
        @(negedge clk);
        shift_in({16'd3, 16'd12, 16'd40, 16'd100}, 64);
        shift_in(64'hFF, 8);
        @(negedge clk);
        sweep(12, 3, 100, 40, 105, "R4 R5 serial chain");

        // R8/R9: partial reset forces flags high, keeps thresholds and mode
        prst_n = 1'b0;
        set_levels(0, 0, 0, 0);
        @(negedge clk);
        @(negedge clk);
        chk(ae1_n & af1_n & ae2_n & af2_n, 1'b1, "R8 flags high in partial reset");
        prst_n = 1'b1;
        shift_in(64'hFFFF, 16);
        par_write(36'h0);
        @(negedge clk);
        sweep(12, 3, 100, 40, 105, "R9 kept across partial reset");

        // R1 R2: mixed levels, each flag against its own threshold
        set_levels(12, 4, 101, 40);
        @(negedge clk);
        chk(ae1_n, 1'b0, "R1 ae1 at equality");
        chk(af1_n, 1'b1, "R2 af1 above");
        chk(ae2_n, 1'b1, "R1 ae2 above");
        chk(af2_n, 1'b0, "R2 af2 at equality");

        summary();
    end
endmodule